// File: doc/BRIEF.md
# Four-Way Multiply-Add-Sum Slice

The slice multiplies four operand pairs (multiplicand and multiplier, each `W` bits), combines the first two products in one add/sub unit and the last two in a second, and then adds the two partial results into a single wide result. Operands are read as two's complement or as unsigned numbers, chosen by one control input. Each add/sub unit has its own control, so the result can be any of `(p0 ± p1) + (p2 ± p3)`.

Three register stages sit on the path: operand input registers, product pipeline registers, and an output register. Each stage can be bypassed with a static parameter, so the latency is 0 to 3 cycles. The slice has a pool of four clock-enable lines and four synchronous, active-high reset lines. Each stage picks one enable and one reset from the pool with static parameters. The multiplicand side, the multiplier side, the pipeline stage and the output stage each make their own choice. The sign and add/sub controls travel through the same registers as the operands, so they always meet the data they belong to.

For building larger structures, the four multiplicand registers and the four multiplier registers can each be set up as a shift chain. In that mode, register 0 loads from a chain input and register k loads from register k-1. Register 3 always drives a chain output, so neighbouring slices can be linked.

The slice has no state machine. The only sequencing is the fixed, parameter-chosen pipeline. Each register holds one of two conditions per cycle: it is cleared when its selected reset line is high, or it loads when its selected enable line is high. Otherwise it keeps its value.

Top module: `quad_mult_sum`

## Requirements
- R1: With `is_signed`=1, all operands are two's complement. `result` equals `(p0 ± p1) + (p2 ± p3)` as a two's-complement value of 2W+2 bits.
- R2: With `is_signed`=0, all operands are unsigned (upper bits treated as zero). `result` equals the same expression taken modulo 2^(2W+2).
- R3: `sub_lo`=1 makes the first unit compute p0-p1 (0 gives p0+p1). `sub_hi`=1 makes the second unit compute p2-p3. The two controls act independently.
- R4: The latency from inputs to `result` equals the number of stages enabled among IN_REG, PIPE_REG and OUT_REG (3 by default). Controls sampled with the operands apply to those operands.
- R5: One cycle after the reset line selected by a stage is high at a clock edge, that stage holds zero. For the output stage this means `result`=0.
- R6: While a stage's selected enable line is low and its reset line is low, its registers keep their value.
- R7: A pool line affects only the stages that select it. A reset of the multiplier-side line leaves the multiplicand side untouched, and an output reset leaves the input stage untouched.
- R8: `chain_a_out` and `chain_b_out` show input register 3 of each side. With the chain option on, a value on `chain_a_in` or `chain_b_in` appears on the matching chain output 4 enabled cycles later.
- R9: Extreme operands give the exact result with no overflow. These are all-ones unsigned operands, and signed operands of -2^(W-1) and 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| ce_pool | input | 4 | Shared clock-enable lines; each stage selects one |
| rst_pool | input | 4 | Shared synchronous active-high reset lines; each stage selects one |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| sub_lo | input | 1 | 1: first unit subtracts p1 from p0 |
| sub_hi | input | 1 | 1: second unit subtracts p3 from p2 |
| mcand | input | 4×W | Multiplicands, lane k in bits [k*W +: W] |
| mplier | input | 4×W | Multipliers, lane k in bits [k*W +: W] |
| chain_a_in | input | W | Multiplicand shift-chain input |
| chain_b_in | input | W | Multiplier shift-chain input |
| chain_a_out | output | W | Multiplicand input register 3 |
| chain_b_out | output | W | Multiplier input register 3 |
| result | output | 2W+2 | Final sum |

## Verification
The assertions cover the output register and the two chain outputs. They assume every pool line is a known 0 or 1 from the first clock edge on, and they stay silent while any line is still unknown. The bench meets this by driving all enables and resets to defined values before the first edge and holding every reset high for several cycles. It changes inputs only on the falling edge, so the registers never sample an input in transition. Random operand and control streams run only while all enables are high. Enable and reset lines are then toggled one at a time in directed steps, after the scoreboard has drained.

// File: rtl/qms_pkg.sv
package qms_pkg;

    localparam int POOL  = 4;
    localparam int SEL_W = $clog2(POOL);
    localparam int LANES = 4;

    // Static choice of one enable line and one reset line from the pool.
    typedef struct packed {
        logic [SEL_W-1:0] ce;
        logic [SEL_W-1:0] rst;
    } pool_sel_t;

endpackage

// File: rtl/qms_sreg.sv
// Optional stage register: synchronous clear has priority over load.
module qms_sreg #(
    parameter int WIDTH = 8,
    parameter bit USE   = 1'b1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] held;

    always_ff @(posedge clk) begin
        if (clr)
            held <= '0;
        else if (en)
            held <= d;
    end

    assign q = USE ? held : d;

endmodule

// File: rtl/qms_mul.sv
// Lane multiplier: extends both operands per the sign mode, keeps 2W bits.
module qms_mul #(
    parameter int W = 18
) (
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int PW = 2 * W;

    logic [PW-1:0] ax;
    logic [PW-1:0] bx;

    assign ax = {{W{sgn & a[W-1]}}, a};
    assign bx = {{W{sgn & b[W-1]}}, b};
    assign p  = PW'(ax * bx);

endmodule

// File: rtl/qms_addsub.sv
// Pair combiner: one bit of growth, sign extension only in signed mode.
module qms_addsub #(
    parameter int PW = 36
) (
    input  logic          sgn,
    input  logic          sub,
    input  logic [PW-1:0] x0,
    input  logic [PW-1:0] x1,
    output logic [PW:0]   r
);

    logic [PW:0] e0;
    logic [PW:0] e1;

    assign e0 = {sgn & x0[PW-1], x0};
    assign e1 = {sgn & x1[PW-1], x1};
    assign r  = sub ? (e0 - e1) : (e0 + e1);

endmodule

// File: rtl/quad_mult_sum.sv
module quad_mult_sum
    import qms_pkg::*;
#(
    parameter int        W        = 18,
    parameter bit        IN_REG   = 1'b1,
    parameter bit        PIPE_REG = 1'b1,
    parameter bit        OUT_REG  = 1'b1,
    parameter bit        A_CHAIN  = 1'b0,
    parameter bit        B_CHAIN  = 1'b0,
    parameter pool_sel_t A_SEL    = '{ce: 2'd0, rst: 2'd0},
    parameter pool_sel_t B_SEL    = '{ce: 2'd1, rst: 2'd1},
    parameter pool_sel_t P_SEL    = '{ce: 2'd2, rst: 2'd2},
    parameter pool_sel_t O_SEL    = '{ce: 2'd3, rst: 2'd3}
) (
    input  logic                      clk,
    input  logic [POOL-1:0]           ce_pool,
    input  logic [POOL-1:0]           rst_pool,
    input  logic                      is_signed,
    input  logic                      sub_lo,
    input  logic                      sub_hi,
    input  logic [LANES-1:0][W-1:0]   mcand,
    input  logic [LANES-1:0][W-1:0]   mplier,
    input  logic [W-1:0]              chain_a_in,
    input  logic [W-1:0]              chain_b_in,
    output logic [W-1:0]              chain_a_out,
    output logic [W-1:0]              chain_b_out,
    output logic [2*W+1:0]            result
);

    localparam int PW  = 2 * W;
    localparam int RW  = PW + 2;
    localparam int CTW = 3;   // {signed, sub_hi, sub_lo}

    logic [W-1:0]   a_d [LANES];
    logic [W-1:0]   a_q [LANES];
    logic [W-1:0]   b_d [LANES];
    logic [W-1:0]   b_q [LANES];
    logic [PW-1:0]  prod   [LANES];
    logic [PW-1:0]  prod_q [LANES];
    logic [CTW-1:0] ctl_in;
    logic [CTW-1:0] ctl_s1;
    logic [CTW-1:0] ctl_s2;
    logic [PW:0]    part_lo;
    logic [PW:0]    part_hi;
    logic [RW-1:0]  sum_d;

    assign ctl_in = {is_signed, sub_hi, sub_lo};

    // Stage 1: operand input registers, optionally linked as shift chains.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_head
            assign a_d[k] = A_CHAIN ? chain_a_in : mcand[k];
            assign b_d[k] = B_CHAIN ? chain_b_in : mplier[k];
        end else begin : g_link
            assign a_d[k] = A_CHAIN ? a_q[k-1] : mcand[k];
            assign b_d[k] = B_CHAIN ? b_q[k-1] : mplier[k];
        end

        qms_sreg #(.WIDTH(W), .USE(IN_REG)) u_a_reg (
            .clk (clk),
            .en  (ce_pool[A_SEL.ce]),
            .clr (rst_pool[A_SEL.rst]),
            .d   (a_d[k]),
            .q   (a_q[k])
        );

        qms_sreg #(.WIDTH(W), .USE(IN_REG)) u_b_reg (
            .clk (clk),
            .en  (ce_pool[B_SEL.ce]),
            .clr (rst_pool[B_SEL.rst]),
            .d   (b_d[k]),
            .q   (b_q[k])
        );

        qms_mul #(.W(W)) u_mul (
            .sgn (ctl_s1[2]),
            .a   (a_q[k]),
            .b   (b_q[k]),
            .p   (prod[k])
        );

        // Stage 2: product pipeline register.
        qms_sreg #(.WIDTH(PW), .USE(PIPE_REG)) u_p_reg (
            .clk (clk),
            .en  (ce_pool[P_SEL.ce]),
            .clr (rst_pool[P_SEL.rst]),
            .d   (prod[k]),
            .q   (prod_q[k])
        );
    end

    // Controls ride with the multiplicand-side input register.
    qms_sreg #(.WIDTH(CTW), .USE(IN_REG)) u_ctl_in_reg (
        .clk (clk),
        .en  (ce_pool[A_SEL.ce]),
        .clr (rst_pool[A_SEL.rst]),
        .d   (ctl_in),
        .q   (ctl_s1)
    );

    qms_sreg #(.WIDTH(CTW), .USE(PIPE_REG)) u_ctl_pipe_reg (
        .clk (clk),
        .en  (ce_pool[P_SEL.ce]),
        .clr (rst_pool[P_SEL.rst]),
        .d   (ctl_s1),
        .q   (ctl_s2)
    );

    qms_addsub #(.PW(PW)) u_pair_lo (
        .sgn (ctl_s2[2]),
        .sub (ctl_s2[0]),
        .x0  (prod_q[0]),
        .x1  (prod_q[1]),
        .r   (part_lo)
    );

    qms_addsub #(.PW(PW)) u_pair_hi (
        .sgn (ctl_s2[2]),
        .sub (ctl_s2[1]),
        .x0  (prod_q[2]),
        .x1  (prod_q[3]),
        .r   (part_hi)
    );

    // A partial result is a signed quantity when operands are signed or the
    // unit subtracted; an unsigned sum of two products is zero-extended.
    always_comb begin
        logic ext_lo;
        logic ext_hi;
        ext_lo = (ctl_s2[2] | ctl_s2[0]) & part_lo[PW];
        ext_hi = (ctl_s2[2] | ctl_s2[1]) & part_hi[PW];
        sum_d  = {ext_lo, part_lo} + {ext_hi, part_hi};
    end

    // Stage 3: output register.
    qms_sreg #(.WIDTH(RW), .USE(OUT_REG)) u_out_reg (
        .clk (clk),
        .en  (ce_pool[O_SEL.ce]),
        .clr (rst_pool[O_SEL.rst]),
        .d   (sum_d),
        .q   (result)
    );

    assign chain_a_out = a_q[LANES-1];
    assign chain_b_out = b_q[LANES-1];

endmodule

// File: rtl/qms_checker.sv
module qms_checker
    import qms_pkg::*;
#(
    parameter int        W       = 18,
    parameter bit        IN_REG  = 1'b1,
    parameter bit        OUT_REG = 1'b1,
    parameter pool_sel_t A_SEL   = '{ce: 2'd0, rst: 2'd0},
    parameter pool_sel_t B_SEL   = '{ce: 2'd1, rst: 2'd1},
    parameter pool_sel_t O_SEL   = '{ce: 2'd3, rst: 2'd3}
) (
    input logic            clk,
    input logic [POOL-1:0] ce_pool,
    input logic [POOL-1:0] rst_pool,
    input logic [W-1:0]    chain_a_out,
    input logic [W-1:0]    chain_b_out,
    input logic [2*W+1:0]  result
);

    logic pool_unknown;
    assign pool_unknown = (^{ce_pool, rst_pool}) === 1'bx;

    if (OUT_REG) begin : g_out
        p_out_clear_r5: assert property (@(posedge clk) disable iff (pool_unknown)
            rst_pool[O_SEL.rst] |=> (result == '0));

        p_out_hold_r6: assert property (@(posedge clk) disable iff (pool_unknown || rst_pool[O_SEL.rst])
            !ce_pool[O_SEL.ce] |=> $stable(result));
    end

    if (IN_REG) begin : g_in
        p_a_clear_r7: assert property (@(posedge clk) disable iff (pool_unknown)
            rst_pool[A_SEL.rst] |=> (chain_a_out == '0));

        p_b_clear_r7: assert property (@(posedge clk) disable iff (pool_unknown)
            rst_pool[B_SEL.rst] |=> (chain_b_out == '0));

        p_a_hold_r6: assert property (@(posedge clk) disable iff (pool_unknown || rst_pool[A_SEL.rst])
            !ce_pool[A_SEL.ce] |=> $stable(chain_a_out));

        p_b_hold_r6: assert property (@(posedge clk) disable iff (pool_unknown || rst_pool[B_SEL.rst])
            !ce_pool[B_SEL.ce] |=> $stable(chain_b_out));
    end

endmodule

bind quad_mult_sum qms_checker #(
    .W       (W),
    .IN_REG  (IN_REG),
    .OUT_REG (OUT_REG),
    .A_SEL   (A_SEL),
    .B_SEL   (B_SEL),
    .O_SEL   (O_SEL)
) u_qms_checker (
    .clk         (clk),
    .ce_pool     (ce_pool),
    .rst_pool    (rst_pool),
    .chain_a_out (chain_a_out),
    .chain_b_out (chain_b_out),
    .result      (result)
);

// File: tb/test_quad_mult_sum.sv
`timescale 1ns/1ps
module test_quad_mult_sum;

    localparam int W   = 18;
    localparam int RW  = 2 * W + 2;
    localparam int LAT = 3;

    typedef struct {
        int            due;
        logic [RW-1:0] val;
        string         tag;
    } exp_t;

    logic                clk = 1'b0;
    logic [3:0]          ce_pool  = 4'hF;
    logic [3:0]          rst_pool = 4'hF;
    logic                is_signed = 1'b0;
    logic                sub_lo = 1'b0;
    logic                sub_hi = 1'b0;
    logic [3:0][W-1:0]   mcand  = '0;
    logic [3:0][W-1:0]   mplier = '0;
    logic [W-1:0]        ch_a_in = '0;
    logic [W-1:0]        ch_b_in = '0;
    logic [W-1:0]        chain_a_out, chain_b_out;
    logic [RW-1:0]       result;
    logic [W-1:0]        k_a_out, k_b_out;
    logic [RW-1:0]       k_result;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_mult_sum #(.W(W)) i_quad_mult_sum (
        .clk(clk), .ce_pool(ce_pool), .rst_pool(rst_pool),
        .is_signed(is_signed), .sub_lo(sub_lo), .sub_hi(sub_hi),
        .mcand(mcand), .mplier(mplier),
        .chain_a_in('0), .chain_b_in('0),
        .chain_a_out(chain_a_out), .chain_b_out(chain_b_out),
        .result(result)
    );

    quad_mult_sum #(.W(W), .A_CHAIN(1'b1), .B_CHAIN(1'b1)) i_quad_mult_sum_chain (
        .clk(clk), .ce_pool(ce_pool), .rst_pool(rst_pool),
        .is_signed(is_signed), .sub_lo(sub_lo), .sub_hi(sub_hi),
        .mcand(mcand), .mplier(mplier),
        .chain_a_in(ch_a_in), .chain_b_in(ch_b_in),
        .chain_a_out(k_a_out), .chain_b_out(k_b_out),
        .result(k_result)
    );

    task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [RW-1:0] golden(input logic [3:0][W-1:0] a, input logic [3:0][W-1:0] b,
                                             input logic sg, input logic s0, input logic s1);
        longint p [4];
        longint lo, hi, tot;
        logic [63:0] bits;
        for (int k = 0; k < 4; k++) begin
            if (sg) p[k] = longint'($signed(a[k])) * longint'($signed(b[k]));
            else    p[k] = longint'({46'd0, a[k]}) * longint'({46'd0, b[k]});
        end
        lo   = s0 ? p[0] - p[1] : p[0] + p[1];
        hi   = s1 ? p[2] - p[3] : p[2] + p[3];
        tot  = lo + hi;
        bits = tot;
        return bits[RW-1:0];
    endfunction

    // Driver: applies one vector at a falling edge and queues its expectation.
    task automatic drive(input logic [3:0][W-1:0] a, input logic [3:0][W-1:0] b,
                         input logic sg, input logic s0, input logic s1, input string tag);
        exp_t e;
        @(negedge clk);
        mcand = a; mplier = b; is_signed = sg; sub_lo = s0; sub_hi = s1;
        e.due = cyc + LAT;
        e.val = golden(a, b, sg, s0, s1);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares results as they emerge after the pipeline latency.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, result, e.val);
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [3:0][W-1:0] a, b;
        logic [W-1:0] hold_a, hold_a2;
        logic [RW-1:0] snap;
        logic [W-1:0] va [12];
        logic [W-1:0] vb [12];

        // Reset state (R5)
        repeat (3) @(negedge clk);
        check("R5 reset result", result, '0);
        check("R5 reset chain a", RW'(chain_a_out), '0);
        check("R5 reset chain b", RW'(chain_b_out), '0);
        rst_pool = 4'h0;

        // Corner operands (R9)
        a = {4{{W{1'b1}}}}; b = {4{{W{1'b1}}}};
        drive(a, b, 1'b0, 1'b0, 1'b0, "R9 unsigned max sum");
        a = {4{{1'b1, {(W-1){1'b0}}}}}; b = a;
        drive(a, b, 1'b1, 1'b0, 1'b0, "R9 signed min squared");
        b = {4{{1'b0, {(W-1){1'b1}}}}};
        drive(a, b, 1'b1, 1'b1, 1'b0, "R9 signed min by max");
        a = {4{{W{1'b1}}}};
        b = {{W{1'b1}}, W'(0), W'(0), {W{1'b1}}};
        drive(a, b, 1'b0, 1'b1, 1'b1, "R3 unsigned subtract negative");

        // Random streams: signed, unsigned, mixed sub controls (R1 R2 R3 R4)
        for (int n = 0; n < 240; n++) begin
            logic sg, s0, s1;
            for (int k = 0; k < 4; k++) begin
                a[k] = W'($urandom);
                b[k] = W'($urandom);
            end
            sg = n[0];
            s0 = n[1];
            s1 = n[2];
            if (sg) drive(a, b, sg, s0, s1, "R1 R3 R4 signed stream");
            else    drive(a, b, sg, s0, s1, "R2 R3 R4 unsigned stream");
            if (n > 0 && n < 20) begin
                // chain_a_out shows lane 3 registered one edge earlier (R8)
                @(negedge clk);
                check("R8 chain_a_out tracks lane 3", RW'(chain_a_out), RW'(a[3]));
                check("R8 chain_b_out tracks lane 3", RW'(chain_b_out), RW'(b[3]));
            end
        end
        while (sb.size() > 0) @(negedge clk);

        // Output hold while its enable is low (R6)
        @(negedge clk);
        ce_pool[3] = 1'b0;
        snap = result;
        for (int n = 0; n < 4; n++) begin
            mcand  = {4{W'($urandom)}};
            mplier = {4{W'($urandom)}};
            @(negedge clk);
            check("R6 output holds with enable low", result, snap);
        end
        ce_pool[3] = 1'b1;

        // Independent selection and input-stage hold (R7 R6 R5)
        hold_a  = W'(18'h1_2345);
        hold_a2 = W'(18'h0_0BEE);
        mcand[3]  = hold_a;
        mplier[3] = W'(18'h0_0777);
        @(negedge clk);
        rst_pool[1] = 1'b1;
        @(negedge clk);
        check("R7 multiplier side cleared", RW'(chain_b_out), '0);
        check("R7 multiplicand side kept", RW'(chain_a_out), RW'(hold_a));
        rst_pool[1] = 1'b0;
        ce_pool[0]  = 1'b0;
        mcand[3]    = hold_a2;
        @(negedge clk);
        check("R6 input stage holds with enable low", RW'(chain_a_out), RW'(hold_a));
        ce_pool[0] = 1'b1;
        @(negedge clk);
        check("R6 input stage loads after enable", RW'(chain_a_out), RW'(hold_a2));
        rst_pool[3] = 1'b1;
        @(negedge clk);
        check("R5 output cleared by its reset", result, '0);
        check("R7 input stage untouched by output reset", RW'(chain_a_out), RW'(hold_a2));
        rst_pool[3] = 1'b0;

        // Shift chain on the second slice (R8)
        for (int i = 0; i < 12; i++) begin
            va[i] = W'($urandom);
            vb[i] = W'($urandom);
        end
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check("R8 chain a four-stage shift", RW'(k_a_out), RW'(va[i-4]));
                check("R8 chain b four-stage shift", RW'(k_b_out), RW'(vb[i-4]));
            end
            ch_a_in = va[i];
            ch_b_in = vb[i];
        end

        finish_run();
    end

endmodule